// File: doc/BRIEF.md
# Two-Register PWM Timer

An 8-bit count engine with two operating modes. In interval mode it is a reload down-counter. Each count tick lowers the counter by one. When a tick finds the counter at zero, the counter reloads from the reload value and an underflow event occurs. When square-wave output is selected, the output flips on every underflow, so it runs at half the underflow rate.

In pulse mode the output is high for `n` ticks and then low for `m` ticks. `n` is the reload value and `m` is a second, independent value, so the high fraction is n/(n+m). Both values are taken together only when a new period begins, so a write during a period cannot cut a phase short.

Count ticks come from one of three single-cycle inputs: a prescaled clock, or the underflow of one of two upstream timers. A halt input freezes counting. An interrupt pulse marks every underflow in interval mode and every low-to-high output transition in pulse mode.

Top module: `twin_reg_pwm_timer`

## Requirements
- R1: While `rst` is high and in the cycle after it, `wave_out` and `irq` are 0. The counter is idle at zero, so the first tick after reset starts the first interval or period.
- R2: `src_sel` selects the tick input: 2'b00 takes `tick_presc`, 2'b01 takes `tick_up5` and 2'b10 takes `tick_up4`. 2'b11 takes no tick. Tick inputs that are not selected have no effect on the outputs.
- R3: While `halt` is 1 no tick is counted, and from the following edge `wave_out` and `irq` stay 0. Count state is held.
- R4: In interval mode (`mode_pwm`=0), a tick that finds the counter at zero reloads it with `reload_val` and produces a one-cycle `irq`. Any other tick decrements the counter. Underflows therefore recur every `reload_val`+1 ticks.
- R5: In interval mode with `sq_en`=1, `wave_out` flips on each underflow. With `sq_en`=0, `wave_out` is 0 and the flip state is cleared, so the first underflow after enabling drives it high.
- R6: In pulse mode (`mode_pwm`=1), each period is high for `n` ticks and then low for `m` ticks, where n=`reload_val` and m=`pwm_val`.
- R7: With n=0, `wave_out` stays 0 in pulse mode.
- R8: With m=0 and n>0, `wave_out` stays 1 once the first period has begun.
- R9: With n=0 and m=0, `wave_out` stays 0: the zero-high rule takes precedence.
- R10: In pulse mode, `irq` pulses for one cycle exactly when `wave_out` goes from low to high because a new high phase begins.
- R11: `n` and `m` are sampled only at the tick that starts a period. Changes made during a period shape the next period.
- R12: A change of `mode_pwm` reinitialises the engine: counter zero, output low, no event in that cycle. A tick arriving in that same cycle is dropped.
- R13: `wave_out` and `irq` are registered. They take their new values at the clock edge that samples the tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_pwm | input | 1 | 0 = interval mode, 1 = pulse mode |
| src_sel | input | 2 | Tick source select |
| halt | input | 1 | 1 = counting stopped, output low |
| sq_en | input | 1 | Square-wave output enable in interval mode |
| reload_val | input | 8 | Reload value / high tick count n |
| pwm_val | input | 8 | Low tick count m |
| tick_presc | input | 1 | Prescaled clock tick |
| tick_up5 | input | 1 | Upstream timer underflow, source 01 |
| tick_up4 | input | 1 | Upstream timer underflow, source 10 |
| wave_out | output | 1 | Timer output |
| irq | output | 1 | Interrupt request pulse |

## Verification
Every result of this block is due at the rising edge that samples a tick, a halt or a mode change, with no further pipeline stage. The bench therefore drives inputs on falling edges and runs its reference model right after each rising edge, using the inputs that edge saw. It compares `wave_out` and `irq` at the next falling edge, exactly one edge after the stimulus. The directed parts also count high cycles and interrupt pulses over whole periods. These counts are computed from `n`, `m` and the reload value, so duty and underflow rate are checked independently of the cycle-level model.

// File: rtl/twin_reg_pwm_timer_pkg.sv
package twin_reg_pwm_timer_pkg;
  localparam int SEL_W = 2;
  localparam int NUM_SRC = 3;

  typedef enum logic [SEL_W-1:0] {
    SRC_PRESC = 2'b00,
    SRC_UP5   = 2'b01,
    SRC_UP4   = 2'b10,
    SRC_NONE  = 2'b11
  } src_e;
endpackage

// File: rtl/twin_reg_pwm_timer_tick_sel.sv
module twin_reg_pwm_timer_tick_sel
  import twin_reg_pwm_timer_pkg::*;
#(
  parameter int NSRC = NUM_SRC
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  input  logic             halt,
  input  logic [NSRC-1:0]  src_tick,
  output logic             tick
);
  logic [NSRC-1:0] hit;

  genvar gi;
  generate
    for (gi = 0; gi < NSRC; gi++) begin : g_src
      assign hit[gi] = (sel == SEL_W'(gi)) && src_tick[gi];
    end
  endgenerate

  assign tick = !halt && (|hit);

  // R2, R3: a counted tick needs a real source and no halt
  p_tick_legal_r2: assert property (@(posedge clk) disable iff (rst)
    tick |-> (src_e'(sel) != SRC_NONE) && !halt);
endmodule

// File: rtl/twin_reg_pwm_timer_core.sv
module twin_reg_pwm_timer_core #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             mode_pwm,
  input  logic             sq_en,
  input  logic [CNT_W-1:0] reload_val,
  input  logic [CNT_W-1:0] pwm_val,
  output logic             hi_d,
  output logic             tog_d,
  output logic             uflow,
  output logic             rise
);
  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] n_q, n_d, m_q, m_d;
  logic             hi_q, tog_q, mode_q;
  logic             restart;

  assign restart = (mode_pwm != mode_q);

  always_comb begin
    cnt_d = cnt_q;
    hi_d  = hi_q;
    tog_d = tog_q;
    n_d   = n_q;
    m_d   = m_q;
    uflow = 1'b0;
    rise  = 1'b0;
    if (restart) begin
      cnt_d = ZERO;
      hi_d  = 1'b0;
      tog_d = 1'b0;
    end else if (!mode_pwm) begin
      hi_d = 1'b0;
      if (tick) begin
        if (cnt_q == ZERO) begin
          cnt_d = reload_val;
          uflow = 1'b1;
          tog_d = ~tog_q;
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end
      if (!sq_en) tog_d = 1'b0;
    end else begin
      tog_d = 1'b0;
      if (tick) begin
        if (cnt_q > ONE) begin
          cnt_d = cnt_q - ONE;
        end else if (hi_q && (m_q != ZERO)) begin
          hi_d  = 1'b0;
          cnt_d = m_q;
        end else begin
          n_d = reload_val;
          m_d = pwm_val;
          if (reload_val != ZERO) begin
            hi_d  = 1'b1;
            cnt_d = reload_val;
            rise  = ~hi_q;
          end else begin
            hi_d  = 1'b0;
            cnt_d = pwm_val;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= ZERO;
      n_q    <= ZERO;
      m_q    <= ZERO;
      hi_q   <= 1'b0;
      tog_q  <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      n_q    <= n_d;
      m_q    <= m_d;
      hi_q   <= hi_d;
      tog_q  <= tog_d;
      mode_q <= mode_pwm;
    end
  end

  // R3, R2: without a tick and without a mode change the count state holds
  p_hold_no_tick_r3: assert property (@(posedge clk) disable iff (rst)
    (!tick && (mode_pwm == mode_q)) |=> ($stable(cnt_q) && $stable(hi_q)));

  // R6: a high phase always has ticks left to run
  p_high_has_count_r6: assert property (@(posedge clk) disable iff (rst)
    hi_q |-> (cnt_q != ZERO));

  // R12: a mode change leaves the engine idle and low
  p_restart_idle_r12: assert property (@(posedge clk) disable iff (rst)
    (mode_pwm != mode_q) |=> (!hi_q && !tog_q && (cnt_q == ZERO)));
endmodule

// File: rtl/twin_reg_pwm_timer_out.sv
module twin_reg_pwm_timer_out (
  input  logic clk,
  input  logic rst,
  input  logic halt,
  input  logic mode_pwm,
  input  logic sq_en,
  input  logic hi_d,
  input  logic tog_d,
  input  logic uflow,
  input  logic rise,
  output logic wave_out,
  output logic irq
);
  logic wave_q, irq_q, pwm_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wave_q <= 1'b0;
      irq_q  <= 1'b0;
      pwm_q  <= 1'b0;
    end else begin
      wave_q <= !halt && (mode_pwm ? hi_d : (tog_d && sq_en));
      irq_q  <= mode_pwm ? rise : uflow;
      pwm_q  <= mode_pwm;
    end
  end

  assign wave_out = wave_q;
  assign irq      = irq_q;

  // R3: a halt forces both outputs low at the next edge
  p_halt_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    halt |=> (!wave_out && !irq));

  // R10: a pulse-mode interrupt comes with the output high
  p_irq_with_high_r10: assert property (@(posedge clk) disable iff (rst)
    (irq && pwm_q) |-> wave_out);
endmodule

// File: rtl/twin_reg_pwm_timer.sv
module twin_reg_pwm_timer
  import twin_reg_pwm_timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_pwm,
  input  logic [1:0]       src_sel,
  input  logic             halt,
  input  logic             sq_en,
  input  logic [CNT_W-1:0] reload_val,
  input  logic [CNT_W-1:0] pwm_val,
  input  logic             tick_presc,
  input  logic             tick_up5,
  input  logic             tick_up4,
  output logic             wave_out,
  output logic             irq
);
  logic [NUM_SRC-1:0] src_tick;
  logic tick, hi_d, tog_d, uflow, rise;

  assign src_tick = {tick_up4, tick_up5, tick_presc};

  twin_reg_pwm_timer_tick_sel #(.NSRC(NUM_SRC)) u_sel (
    .clk(clk), .rst(rst), .sel(src_sel), .halt(halt),
    .src_tick(src_tick), .tick(tick)
  );

  twin_reg_pwm_timer_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .tick(tick), .mode_pwm(mode_pwm), .sq_en(sq_en),
    .reload_val(reload_val), .pwm_val(pwm_val),
    .hi_d(hi_d), .tog_d(tog_d), .uflow(uflow), .rise(rise)
  );

  twin_reg_pwm_timer_out u_out (
    .clk(clk), .rst(rst), .halt(halt), .mode_pwm(mode_pwm), .sq_en(sq_en),
    .hi_d(hi_d), .tog_d(tog_d), .uflow(uflow), .rise(rise),
    .wave_out(wave_out), .irq(irq)
  );

  // R1: outputs are low in the cycle after reset
  p_reset_low_r1: assert property (@(posedge clk)
    rst |=> (!wave_out && !irq));
endmodule

// File: tb/twin_reg_pwm_timer_tb.sv
module twin_reg_pwm_timer_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_pwm = 1'b0, halt = 1'b0, sq_en = 1'b0;
  logic [1:0] src_sel = 2'b00;
  logic [7:0] reload_val = 8'd0, pwm_val = 8'd0;
  logic tick_presc = 1'b0, tick_up5 = 1'b0, tick_up4 = 1'b0;
  logic wave_out, irq;

  int checks = 0, fails = 0;
  string cur_req = "R1";

  int m_cnt = 0, m_n = 0, m_m = 0;
  bit m_hi = 0, m_tog = 0, m_mode = 0, exp_wave = 0, exp_irq = 0;

  always #2 clk = ~clk;

  twin_reg_pwm_timer #(.CNT_W(8)) u_dut (
    .clk(clk), .rst(rst), .mode_pwm(mode_pwm), .src_sel(src_sel), .halt(halt),
    .sq_en(sq_en), .reload_val(reload_val), .pwm_val(pwm_val),
    .tick_presc(tick_presc), .tick_up5(tick_up5), .tick_up4(tick_up4),
    .wave_out(wave_out), .irq(irq)
  );

  function automatic bit sel_tick(bit hlt, logic [1:0] s, bit tp, bit t5, bit t4);
    if (hlt) return 0;
    case (s)
      2'b00: return tp;
      2'b01: return t5;
      2'b10: return t4;
      default: return 0;
    endcase
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // reference model step, run with the inputs seen at the rising edge
  task automatic model_edge();
    bit tk, uf, rs;
    uf = 0; rs = 0;
    if (rst) begin
      m_cnt = 0; m_n = 0; m_m = 0; m_hi = 0; m_tog = 0; m_mode = 0;
    end else begin
      tk = sel_tick(halt, src_sel, tick_presc, tick_up5, tick_up4);
      if (mode_pwm != m_mode) begin
        m_mode = mode_pwm; m_cnt = 0; m_hi = 0; m_tog = 0;
      end else if (!mode_pwm) begin
        if (tk) begin
          if (m_cnt == 0) begin m_cnt = reload_val; uf = 1; m_tog = sq_en ? !m_tog : 0; end
          else m_cnt--;
        end
        if (!sq_en) m_tog = 0;
      end else if (tk) begin
        if (m_cnt > 1) m_cnt--;
        else if (m_hi && m_m != 0) begin m_hi = 0; m_cnt = m_m; end
        else begin
          m_n = reload_val; m_m = pwm_val;
          if (m_n != 0) begin rs = !m_hi; m_hi = 1; m_cnt = m_n; end
          else begin m_hi = 0; m_cnt = m_m; end
        end
      end
    end
    exp_wave = !rst && !halt && (mode_pwm ? m_hi : (m_tog && sq_en));
    exp_irq  = !rst && (mode_pwm ? rs : uf);
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(wave_out == exp_wave, cur_req, "wave_out", wave_out, exp_wave);
    chk(irq == exp_irq, cur_req, "irq", irq, exp_irq);
  endtask

  task automatic restart_mode(bit pm);
    mode_pwm = ~pm; step();
    mode_pwm = pm; step();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int cnt_a, cnt_b;
    void'($urandom(32'd20250611));
    @(negedge clk);
    // R1: reset state
    cur_req = "R1";
    repeat (3) step();
    rst = 1'b0;
    step();
    chk(!wave_out && !irq, "R1", "idle after reset", wave_out, 0);

    // R4, R5, R13: interval mode, reload 3, tick every cycle
    cur_req = "R4"; sq_en = 1; reload_val = 8'd3; tick_presc = 1;
    cnt_a = 0; cnt_b = 0;
    for (int i = 0; i < 40; i++) begin
      bit prev; prev = wave_out; step();
      cnt_a += irq; cnt_b += (wave_out != prev);
    end
    chk(cnt_a == 10, "R4", "underflows in 40 ticks", cnt_a, 10);
    chk(cnt_b == 10, "R5", "output flips in 40 ticks", cnt_b, 10);

    // R5: square output disabled
    cur_req = "R5"; sq_en = 0; cnt_a = 0;
    for (int i = 0; i < 12; i++) begin step(); cnt_a += wave_out; end
    chk(cnt_a == 0, "R5", "output high with sq_en=0", cnt_a, 0);
    sq_en = 1;

    // R2: source 11 counts nothing
    cur_req = "R2"; reload_val = 0; src_sel = 2'b11;
    tick_presc = 1; tick_up4 = 1; tick_up5 = 1; cnt_a = 0;
    for (int i = 0; i < 20; i++) begin step(); cnt_a += irq; end
    chk(cnt_a == 0, "R2", "irq with source 11", cnt_a, 0);
    // R2: source 01 uses only tick_up5
    src_sel = 2'b01; tick_up5 = 0; cnt_a = 0;
    for (int i = 0; i < 10; i++) begin step(); cnt_a += irq; end
    chk(cnt_a == 0, "R2", "irq from unselected inputs", cnt_a, 0);
    src_sel = 2'b10; cnt_a = 0;
    for (int i = 0; i < 10; i++) begin step(); cnt_a += irq; end
    chk(cnt_a == 10, "R2", "irq from tick_up4 each tick", cnt_a, 10);

    // R3: halt
    cur_req = "R3"; halt = 1; cnt_a = 0;
    for (int i = 0; i < 10; i++) begin step(); cnt_a += irq + wave_out; end
    chk(cnt_a == 0, "R3", "activity while halted", cnt_a, 0);
    halt = 0; tick_up4 = 0; src_sel = 2'b00;

    // R6, R12: pulse mode n=3 m=2, tick every cycle
    cur_req = "R12"; reload_val = 8'd3; pwm_val = 8'd2;
    restart_mode(1'b1);
    chk(!wave_out, "R12", "low right after mode change", wave_out, 0);
    cur_req = "R6"; cnt_a = 0; cnt_b = 0;
    for (int i = 0; i < 25; i++) begin step(); cnt_a += wave_out; cnt_b += irq; end
    chk(cnt_a == 15, "R6", "high cycles in 5 periods", cnt_a, 15);
    chk(cnt_b == 5, "R10", "rising-edge irqs in 5 periods", cnt_b, 5);

    // R11: change mid-period; the current period keeps its values
    cur_req = "R11"; step(); reload_val = 8'd1; pwm_val = 8'd1;
    for (int i = 0; i < 12; i++) step();

    // R7: n=0
    cur_req = "R7"; reload_val = 0; pwm_val = 8'd4; restart_mode(1'b1); cnt_a = 0;
    for (int i = 0; i < 20; i++) begin step(); cnt_a += wave_out + irq; end
    chk(cnt_a == 0, "R7", "activity with n=0", cnt_a, 0);

    // R8: m=0
    cur_req = "R8"; reload_val = 8'd5; pwm_val = 0; restart_mode(1'b1); cnt_a = 0;
    for (int i = 0; i < 20; i++) begin step(); cnt_a += wave_out; end
    chk(cnt_a == 20, "R8", "high cycles with m=0", cnt_a, 20);

    // R9: both zero
    cur_req = "R9"; reload_val = 0; restart_mode(1'b1); cnt_a = 0;
    for (int i = 0; i < 20; i++) begin step(); cnt_a += wave_out; end
    chk(cnt_a == 0, "R9", "high cycles with n=m=0", cnt_a, 0);

    // R13, R10: constrained random blocks
    cur_req = "R13";
    for (int b = 0; b < 100; b++) begin
      mode_pwm   = 1'($urandom_range(1));
      src_sel    = ($urandom_range(7) == 0) ? 2'b11 : 2'($urandom_range(2));
      sq_en      = 1'($urandom_range(1));
      reload_val = 8'($urandom_range(5));
      pwm_val    = 8'($urandom_range(5));
      for (int i = 0; i < 40; i++) begin
        halt       = ($urandom_range(9) == 0);
        tick_presc = 1'($urandom_range(1));
        tick_up5   = 1'($urandom_range(1));
        tick_up4   = 1'($urandom_range(1));
        if ($urandom_range(15) == 0) reload_val = 8'($urandom_range(5));
        if ($urandom_range(15) == 0) pwm_val = 8'($urandom_range(5));
        step();
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule